// File: doc/BRIEF.md
# Streaming DMA Descriptor Intake Classifier

This block sits where user logic hands host-to-card streaming descriptors to a DMA engine. Each descriptor arrives over a valid/ready handshake. It carries an address, a byte length, packet framing flags, a status/interrupt request, a marker request, a no-data flag, an error flag, a queue number, a function number, a consumer index and a port number. The block checks each descriptor against the framing and flag rules and against a small per-queue context. It then loads one action record into a single-entry output register. The record tells the downstream engine what to do: read data, write back status, raise an interrupt, return a marker, or mark the queue as broken.

The per-queue context holds four bits for each queue: a sticky error bit, an armed bit, an in-packet bit and, through a static input vector, an interrupt-enable bit. An interrupt is produced only when both the enable bit and the armed bit of the queue are set. Issuing the interrupt disarms the queue. A separate arm strobe re-arms a queue. A no-data descriptor that requests neither status nor marker is swallowed without producing a record.

Top module: `h2c_dsc_classifier`

## Requirements
- R1: A descriptor is taken in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high exactly when the output register is empty. A taken descriptor that yields a record makes `act_valid` high from the next cycle. The record stays unchanged until a cycle with `act_ready` high.
- R2: A processed descriptor with the no-data flag clear sets `act_rd` and copies its address and length to `act_addr` and `act_len`.
- R3: A descriptor with the no-data flag set gives `act_rd` = 0. For it, `act_addr` and `act_len` read zero whatever was driven. The same zeroing holds for every record without `act_rd`.
- R4: A well-framed no-data descriptor with status and marker requests both clear produces no record, and `in_ready` stays high.
- R5: The following descriptors are illegal: one with the status request or the marker request set but end-of-packet clear, and one with the no-data flag set without both start- and end-of-packet. An illegal descriptor yields a record with `act_err` = 1 and `act_bad` = 1 and no other action, and it sets the error bit of its queue.
- R6: A descriptor with `in_err` set, or one addressed to a queue whose error bit is set, yields a record with only `act_err` = 1 (`act_bad` = 0). It sets the error bit of the queue, and that bit stays set until reset.
- R7: A processed descriptor with the status request set gives `act_wb` = 1. Its consumer index appears unchanged on `act_cidx`.
- R8: `act_irq` is 1 only on a status record whose queue has its `irq_en` bit set and its armed bit set. Emitting it clears the armed bit. A pulse on `arm_valid` with `arm_qid` sets the armed bit. When the arm pulse comes in the same cycle as the disarm, the queue ends up armed.
- R9: A processed descriptor with the marker request set gives `act_mrkr` = 1.
- R10: Per queue, start-of-packet is legal only outside a packet, and a descriptor without start-of-packet is legal only inside one. End-of-packet closes the packet. A violation is handled as in R5.
- R11: A queue number of `NQ` or above is illegal (handled as in R5, with no context change).
- R12: Every record carries the descriptor's queue, function, port and consumer index.
- R13: After reset, `act_valid` is 0, `in_ready` is 1, and every queue is unarmed, error-free and outside a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Descriptor accepted this cycle when high with valid |
| in_addr | input | 64 | Source address |
| in_len | input | 16 | Byte count |
| in_sop | input | 1 | First descriptor of a packet |
| in_eop | input | 1 | Last descriptor of a packet |
| in_sdi | input | 1 | Status writeback / interrupt request |
| in_mrkr | input | 1 | Marker request |
| in_nodata | input | 1 | No data movement for this descriptor |
| in_err | input | 1 | Caller-flagged queue error |
| in_qid | input | 11 | Queue number |
| in_func | input | 8 | Function number |
| in_cidx | input | 16 | Consumer index for status |
| in_port | input | 3 | Port number |
| arm_valid | input | 1 | Arm strobe |
| arm_qid | input | 11 | Queue to arm |
| irq_en | input | NQ | Per-queue interrupt enable |
| act_valid | output | 1 | Action record present |
| act_ready | input | 1 | Downstream takes the record |
| act_rd | output | 1 | Issue data read |
| act_wb | output | 1 | Issue status writeback |
| act_irq | output | 1 | Raise interrupt |
| act_mrkr | output | 1 | Return marker |
| act_err | output | 1 | Queue marked errored |
| act_bad | output | 1 | Descriptor broke a rule |
| act_addr | output | 64 | Read address |
| act_len | output | 16 | Read length |
| act_qid | output | 11 | Queue number |
| act_func | output | 8 | Function number |
| act_port | output | 3 | Port number |
| act_cidx | output | 16 | Consumer index |

## Verification
Several properties are checked on every cycle: a stalled record stays put, a record never appears without a descriptor having been offered, a record without a read carries zero address and length, an error record carries no other action, an interrupt always comes with a writeback, and an illegal flag always comes with the error flag. Other behaviours depend on history, and only the bench's scenarios can show them. These are the arming and disarming of interrupts (including an arm in the same cycle as a disarm), the stickiness of a queue error, packet framing across several descriptors, and the silent swallowing of a no-data NOP. The bench follows them with its own per-queue model.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    parameter int ADDR_W = 64;
    parameter int LEN_W  = 16;
    parameter int QID_W  = 11;
    parameter int FN_W   = 8;
    parameter int CIDX_W = 16;
    parameter int PORT_W = 3;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              sop;
        logic              eop;
        logic              sdi;
        logic              mrkr;
        logic              nodata;
        logic              err;
        logic [QID_W-1:0]  qid;
        logic [FN_W-1:0]   func;
        logic [CIDX_W-1:0] cidx;
        logic [PORT_W-1:0] port;
    } dsc_t;

    typedef struct packed {
        logic              rd;
        logic              wb;
        logic              irq;
        logic              mrkr;
        logic              err;
        logic              bad;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [QID_W-1:0]  qid;
        logic [FN_W-1:0]   func;
        logic [PORT_W-1:0] port;
        logic [CIDX_W-1:0] cidx;
    } act_t;

    typedef enum logic [1:0] {
        CLS_NOP,
        CLS_RUN,
        CLS_ERR,
        CLS_BAD
    } cls_e;

    // Flag combinations that are legal regardless of queue state.
    function automatic logic flags_ok(dsc_t d);
        logic ok;
        ok = 1'b1;
        if ((d.sdi || d.mrkr) && !d.eop) ok = 1'b0;
        if (d.nodata && !(d.sop && d.eop)) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic is_nop(dsc_t d);
        return d.nodata && !d.sdi && !d.mrkr;
    endfunction

endpackage

// File: rtl/dsc_rule_check.sv
module dsc_rule_check
    import dsc_pkg::*;
(
    input  dsc_t d,
    input  logic in_pkt,
    output logic bad
);
    logic frame_bad;

    always_comb begin
        frame_bad = (d.sop && in_pkt) || (!d.sop && !in_pkt);
        bad = frame_bad || !flags_ok(d);
    end
endmodule

// File: rtl/dsc_ctx_table.sv
module dsc_ctx_table #(
    parameter int NQ = 16,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd_en,
    input  logic [QW-1:0] upd_idx,
    input  logic          upd_err,
    input  logic          upd_inpkt,
    input  logic          upd_disarm,
    input  logic          arm_en,
    input  logic [QW-1:0] arm_idx,
    input  logic [QW-1:0] rd_idx,
    output logic          rd_err,
    output logic          rd_armed,
    output logic          rd_inpkt
);
    logic [NQ-1:0] err_v;
    logic [NQ-1:0] arm_v;
    logic [NQ-1:0] pkt_v;

    for (genvar q = 0; q < NQ; q++) begin : g_q
        logic hit_u;
        logic hit_a;
        assign hit_u = upd_en && (upd_idx == QW'(q));
        assign hit_a = arm_en && (arm_idx == QW'(q));

        always_ff @(posedge clk) begin
            if (rst) begin
                err_v[q] <= 1'b0;
                arm_v[q] <= 1'b0;
                pkt_v[q] <= 1'b0;
            end else begin
                if (hit_u) begin
                    if (upd_err)    err_v[q] <= 1'b1;
                    if (upd_disarm) arm_v[q] <= 1'b0;
                    pkt_v[q] <= upd_inpkt;
                end
                // Arming after the disarm lets a same-cycle arm win.
                if (hit_a) arm_v[q] <= 1'b1;
            end
        end
    end

    assign rd_err   = err_v[rd_idx];
    assign rd_armed = arm_v[rd_idx];
    assign rd_inpkt = pkt_v[rd_idx];
endmodule

// File: rtl/dsc_act_reg.sv
module dsc_act_reg
    import dsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  act_t d,
    input  logic take,
    output logic valid,
    output act_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            q     <= '0;
        end else if (load) begin
            valid <= 1'b1;
            q     <= d;
        end else if (take) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/h2c_dsc_classifier.sv
module h2c_dsc_classifier
    import dsc_pkg::*;
#(
    parameter int NQ = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LEN_W-1:0]  in_len,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_sdi,
    input  logic              in_mrkr,
    input  logic              in_nodata,
    input  logic              in_err,
    input  logic [QID_W-1:0]  in_qid,
    input  logic [FN_W-1:0]   in_func,
    input  logic [CIDX_W-1:0] in_cidx,
    input  logic [PORT_W-1:0] in_port,
    input  logic              arm_valid,
    input  logic [QID_W-1:0]  arm_qid,
    input  logic [NQ-1:0]     irq_en,
    output logic              act_valid,
    input  logic              act_ready,
    output logic              act_rd,
    output logic              act_wb,
    output logic              act_irq,
    output logic              act_mrkr,
    output logic              act_err,
    output logic              act_bad,
    output logic [ADDR_W-1:0] act_addr,
    output logic [LEN_W-1:0]  act_len,
    output logic [QID_W-1:0]  act_qid,
    output logic [FN_W-1:0]   act_func,
    output logic [PORT_W-1:0] act_port,
    output logic [CIDX_W-1:0] act_cidx
);
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;

    dsc_t          dsc;
    act_t          nxt;
    act_t          cur;
    cls_e          cls;
    logic          acc;
    logic          q_ok;
    logic          a_ok;
    logic [QW-1:0] idx;
    logic [QW-1:0] a_idx;
    logic          c_err, c_armed, c_inpkt;
    logic          rule_bad;
    logic          upd_err, upd_inpkt;

    assign dsc = '{addr: in_addr, len: in_len, sop: in_sop, eop: in_eop,
                   sdi: in_sdi, mrkr: in_mrkr, nodata: in_nodata, err: in_err,
                   qid: in_qid, func: in_func, cidx: in_cidx, port: in_port};

    assign in_ready = !act_valid;
    assign acc      = in_valid && in_ready;
    assign q_ok     = in_qid < QID_W'(NQ);
    assign a_ok     = arm_qid < QID_W'(NQ);
    assign idx      = in_qid[QW-1:0];
    assign a_idx    = arm_qid[QW-1:0];

    dsc_rule_check u_rule (
        .d      (dsc),
        .in_pkt (c_inpkt),
        .bad    (rule_bad)
    );

    always_comb begin
        if (!q_ok)                    cls = CLS_BAD;
        else if (in_err || c_err)     cls = CLS_ERR;
        else if (rule_bad)            cls = CLS_BAD;
        else if (is_nop(dsc))         cls = CLS_NOP;
        else                          cls = CLS_RUN;
    end

    always_comb begin
        nxt      = '0;
        nxt.qid  = in_qid;
        nxt.func = in_func;
        nxt.port = in_port;
        nxt.cidx = in_cidx;
        case (cls)
            CLS_RUN: begin
                nxt.rd   = !in_nodata;
                nxt.addr = in_nodata ? '0 : in_addr;
                nxt.len  = in_nodata ? '0 : in_len;
                nxt.wb   = in_sdi;
                nxt.irq  = in_sdi && irq_en[idx] && c_armed;
                nxt.mrkr = in_mrkr;
            end
            CLS_ERR: nxt.err = 1'b1;
            CLS_BAD: begin
                nxt.err = 1'b1;
                nxt.bad = 1'b1;
            end
            default: ;
        endcase
    end

    assign upd_err   = (cls == CLS_ERR) || (cls == CLS_BAD);
    assign upd_inpkt = upd_err ? c_inpkt : !in_eop;

    dsc_ctx_table #(.NQ(NQ)) u_ctx (
        .clk        (clk),
        .rst        (rst),
        .upd_en     (acc && q_ok),
        .upd_idx    (idx),
        .upd_err    (upd_err),
        .upd_inpkt  (upd_inpkt),
        .upd_disarm (nxt.irq),
        .arm_en     (arm_valid && a_ok),
        .arm_idx    (a_idx),
        .rd_idx     (idx),
        .rd_err     (c_err),
        .rd_armed   (c_armed),
        .rd_inpkt   (c_inpkt)
    );

    dsc_act_reg u_out (
        .clk   (clk),
        .rst   (rst),
        .load  (acc && (cls != CLS_NOP)),
        .d     (nxt),
        .take  (act_ready),
        .valid (act_valid),
        .q     (cur)
    );

    assign act_rd   = cur.rd;
    assign act_wb   = cur.wb;
    assign act_irq  = cur.irq;
    assign act_mrkr = cur.mrkr;
    assign act_err  = cur.err;
    assign act_bad  = cur.bad;
    assign act_addr = cur.addr;
    assign act_len  = cur.len;
    assign act_qid  = cur.qid;
    assign act_func = cur.func;
    assign act_port = cur.port;
    assign act_cidx = cur.cidx;
endmodule

// File: rtl/h2c_dsc_classifier_chk.sv
module h2c_dsc_classifier_chk
    import dsc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              act_valid,
    input logic              act_ready,
    input logic              act_rd,
    input logic              act_wb,
    input logic              act_irq,
    input logic              act_mrkr,
    input logic              act_err,
    input logic              act_bad,
    input logic [ADDR_W-1:0] act_addr,
    input logic [LEN_W-1:0]  act_len,
    input logic [QID_W-1:0]  act_qid,
    input logic [CIDX_W-1:0] act_cidx
);
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        act_valid && !act_ready |=> act_valid && $stable(act_qid) && $stable(act_cidx)
            && $stable({act_rd, act_wb, act_irq, act_mrkr, act_err, act_bad}));

    p_load_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(act_valid) |-> $past(in_valid));

    p_noread_r3: assert property (@(posedge clk) disable iff (rst)
        act_valid && !act_rd |-> act_addr == '0 && act_len == '0);

    p_bad_r5: assert property (@(posedge clk) disable iff (rst)
        act_valid && act_bad |-> act_err);

    p_erronly_r6: assert property (@(posedge clk) disable iff (rst)
        act_valid && act_err |-> !act_rd && !act_wb && !act_irq && !act_mrkr);

    p_irqwb_r8: assert property (@(posedge clk) disable iff (rst)
        act_valid && act_irq |-> act_wb);
endmodule

bind h2c_dsc_classifier h2c_dsc_classifier_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .act_valid (act_valid),
    .act_ready (act_ready),
    .act_rd    (act_rd),
    .act_wb    (act_wb),
    .act_irq   (act_irq),
    .act_mrkr  (act_mrkr),
    .act_err   (act_err),
    .act_bad   (act_bad),
    .act_addr  (act_addr),
    .act_len   (act_len),
    .act_qid   (act_qid),
    .act_cidx  (act_cidx)
);

// File: tb/h2c_dsc_classifier_tb.sv
module h2c_dsc_classifier_tb;
    import dsc_pkg::*;

    localparam int NQ = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [LEN_W-1:0]  in_len = '0;
    logic in_sop = 0, in_eop = 0, in_sdi = 0, in_mrkr = 0, in_nodata = 0, in_err = 0;
    logic [QID_W-1:0]  in_qid = '0;
    logic [FN_W-1:0]   in_func = '0;
    logic [CIDX_W-1:0] in_cidx = '0;
    logic [PORT_W-1:0] in_port = '0;
    logic              arm_valid = 1'b0;
    logic [QID_W-1:0]  arm_qid = '0;
    logic [NQ-1:0]     irq_en = 16'h00FF;
    logic              act_valid;
    logic              act_ready = 1'b0;
    logic act_rd, act_wb, act_irq, act_mrkr, act_err, act_bad;
    logic [ADDR_W-1:0] act_addr;
    logic [LEN_W-1:0]  act_len;
    logic [QID_W-1:0]  act_qid;
    logic [FN_W-1:0]   act_func;
    logic [PORT_W-1:0] act_port;
    logic [CIDX_W-1:0] act_cidx;

    h2c_dsc_classifier #(.NQ(NQ)) u_dut (.*);

    int checks = 0;
    int failures = 0;
    act_t  exp_q[$];
    string tag_q[$];
    bit m_err[NQ];
    bit m_arm[NQ];
    bit m_pkt[NQ];
    bit stall = 0;
    int cyc = 0;

    task automatic check(bit ok, string tag, logic [255:0] got, logic [255:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // Downstream ready pattern with periodic gaps and an explicit stall.
    always @(negedge clk) begin
        cyc++;
        act_ready <= !stall && (cyc % 5 != 2);
    end

    // Monitor: compare each record as it is taken.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && act_valid && act_ready) begin
                act_t g;
                g = '{rd: act_rd, wb: act_wb, irq: act_irq, mrkr: act_mrkr,
                      err: act_err, bad: act_bad, addr: act_addr, len: act_len,
                      qid: act_qid, func: act_func, port: act_port, cidx: act_cidx};
                if (exp_q.size() == 0) begin
                    check(0, "R4 unexpected record", 256'(g), 0);
                end else begin
                    act_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(g == e, t, 256'(g), 256'(e));
                end
            end
        end
    end

    // Driver: model the expected record, then present the descriptor.
    task automatic send(input logic [63:0] a, input logic [15:0] l,
                        input bit sop, eop, sdi, mk, nd, er,
                        input logic [10:0] q, input logic [15:0] c,
                        input bit arm_same, input string tag);
        act_t e;
        bit ok, bad, nop;
        int qi;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        e = '0;
        e.qid = q; e.func = q[7:0] ^ 8'h5A; e.port = q[2:0]; e.cidx = c;
        ok = q < NQ;
        qi = ok ? int'(q) : 0;
        nop = 0;
        if (!ok) begin
            e.err = 1; e.bad = 1;
        end else if (er || m_err[qi]) begin
            e.err = 1; m_err[qi] = 1;
        end else begin
            bad = ((sdi || mk) && !eop) || (nd && !(sop && eop))
                  || (sop && m_pkt[qi]) || (!sop && !m_pkt[qi]);
            if (bad) begin
                e.err = 1; e.bad = 1; m_err[qi] = 1;
            end else begin
                nop = nd && !sdi && !mk;
                m_pkt[qi] = !eop;
                e.rd = !nd;
                if (!nd) begin e.addr = a; e.len = l; end
                e.wb = sdi;
                e.irq = sdi && irq_en[qi] && m_arm[qi];
                e.mrkr = mk;
                if (e.irq) m_arm[qi] = 0;
            end
        end
        if (arm_same && ok) m_arm[qi] = 1;
        if (!nop) begin
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        in_addr = a; in_len = l; in_sop = sop; in_eop = eop; in_sdi = sdi;
        in_mrkr = mk; in_nodata = nd; in_err = er; in_qid = q;
        in_func = q[7:0] ^ 8'h5A; in_port = q[2:0]; in_cidx = c;
        in_valid = 1;
        arm_valid = arm_same; arm_qid = q;
        @(negedge clk);
        in_valid = 0; arm_valid = 0;
    endtask

    task automatic arm(input logic [10:0] q);
        @(negedge clk);
        arm_valid = 1; arm_qid = q;
        @(negedge clk);
        arm_valid = 0;
        if (q < NQ) m_arm[int'(q)] = 1;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NQ; i++) begin m_err[i] = 0; m_arm[i] = 0; m_pkt[i] = 0; end
        repeat (3) @(negedge clk);
        check(act_valid == 0 && in_ready == 1, "R13 reset outputs", {act_valid, in_ready}, 2'b01);
        rst = 0;

        // R2 R7 single-descriptor packet with status, queue not armed (R8)
        send(64'h1000_2000_3000_4000, 16'd512, 1,1,1,0,0,0, 0, 16'h0011, 0, "R2 R7 R12 read+status");
        // R8 armed queue interrupts once, then is disarmed
        arm(0);
        send(64'hA0, 16'd64, 1,1,1,0,0,0, 0, 16'h0022, 0, "R8 armed irq");
        send(64'hB0, 16'd64, 1,1,1,0,0,0, 0, 16'h0023, 0, "R8 disarmed after irq");
        // R8 enable bit clear blocks the interrupt
        arm(9);
        send(64'hC0, 16'd8, 1,1,1,0,0,0, 9, 16'h0031, 0, "R8 irq disabled");
        // R8 same-cycle arm and disarm leaves queue armed
        arm(7);
        send(64'hD0, 16'd8, 1,1,1,0,0,0, 7, 16'h0041, 1, "R8 irq with same-cycle arm");
        send(64'hD8, 16'd8, 1,1,1,0,0,0, 7, 16'h0042, 0, "R8 rearmed irq");
        // R9 R10 three-descriptor packet with marker on the last
        send(64'h100, 16'd100, 1,0,0,0,0,0, 1, 16'h0051, 0, "R10 R2 packet first");
        send(64'h200, 16'd200, 0,0,0,0,0,0, 1, 16'h0052, 0, "R10 R2 packet middle");
        send(64'h300, 16'd300, 0,1,0,1,0,0, 1, 16'h0053, 0, "R9 packet last marker");
        // R3 no-data with status: no read, address/length zeroed
        send(64'hDEAD_BEEF, 16'hFFFF, 1,1,1,0,1,0, 10, 16'h0061, 0, "R3 nodata status");
        send(64'h1234, 16'h4321, 1,1,0,1,1,0, 10, 16'h0062, 0, "R3 R9 nodata marker");
        // R4 NOP produces nothing
        drain();
        send(64'h55, 16'd5, 1,1,0,0,1,0, 11, 16'h0071, 0, "R4 nop");
        repeat (3) @(negedge clk);
        check(act_valid == 0 && in_ready == 1, "R4 nop silent", {act_valid, in_ready}, 2'b01);
        send(64'h66, 16'd6, 1,1,0,0,0,0, 11, 16'h0072, 0, "R4 queue usable after nop");
        // R5 status without eop, then R6 sticky error on that queue
        send(64'h77, 16'd7, 1,0,1,0,0,0, 2, 16'h0081, 0, "R5 status without eop");
        send(64'h78, 16'd7, 1,1,0,0,0,0, 2, 16'h0082, 0, "R6 sticky queue error");
        // R5 marker without eop, no-data without sop
        send(64'h79, 16'd7, 1,0,0,1,0,0, 8, 16'h0091, 0, "R5 marker without eop");
        send(64'h7A, 16'd7, 0,1,0,0,1,0, 4, 16'h00A1, 0, "R5 nodata without sop");
        // R6 caller error flag
        send(64'h7B, 16'd7, 1,1,1,1,0,1, 3, 16'h00B1, 0, "R6 error flag");
        send(64'h7C, 16'd7, 1,1,0,0,0,0, 3, 16'h00B2, 0, "R6 error persists");
        // R10 framing violations
        send(64'h80, 16'd1, 1,0,0,0,0,0, 5, 16'h00C1, 0, "R10 open packet");
        send(64'h81, 16'd1, 1,1,0,0,0,0, 5, 16'h00C2, 0, "R10 sop inside packet");
        send(64'h82, 16'd1, 0,1,0,0,0,0, 6, 16'h00C3, 0, "R10 continuation outside packet");
        // R11 out-of-range queue
        send(64'h83, 16'd1, 1,1,0,0,0,0, 11'd20, 16'h00D1, 0, "R11 queue out of range");
        // R1 backpressure: record held, ready low
        drain();
        stall = 1;
        send(64'h90, 16'd9, 1,1,0,0,0,0, 12, 16'h00E1, 0, "R1 held record");
        repeat (4) @(negedge clk);
        #1;
        check(act_valid == 1 && in_ready == 0 && act_qid == 11'd12, "R1 hold under backpressure",
              {act_valid, in_ready, act_qid}, {1'b1, 1'b0, 11'd12});
        stall = 0;
        for (int k = 0; k < 6; k++)
            send(64'h1000 + 64'(k), 16'(k + 1), 1,1,k[0],0,0,0, 13, 16'(k), 0, "R1 R2 stream");
        drain();
        check(exp_q.size() == 0, "R1 all records delivered", 256'(exp_q.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule